// File: doc/BRIEF.md
# System I/O Control Port Block

This block sits on a byte-wide, ISA-style I/O port bus. It decodes one-byte reads and writes to a small fixed set of port addresses. Three of these ports are writable registers. One is a soft-reset flag whose value drives a soft-reset output. One is a system control byte that keeps only its upper nibble. One is an I/O map type flag whose value drives a non-contiguous-map output and which comes out of reset set.

Two read-only ports return the live values of the equipment strap pins and the board identity strap pins. A keylock status port always reads zero. Several write-only ports accept writes and discard them.

Within each byte the bits are numbered MSB-first, so bit n has the value 1<<(7-n). Setting the little-endian request bit in a soft-reset write raises a sticky error output, because that mode is not supported. Read data is registered.

Top module: `sysio_regs`

## Requirements
- R1: After reset the soft-reset flag, the control byte and the error flag are 0, the map flag is 1 (so `map_noncontig_o`=1), and `io_rdata` is 0x00.
- R2: A write to 0x092 stores data value 0x01 (MSB-first bit 7) as the soft-reset flag. `soft_reset_o` follows it from the write edge on. A read of 0x092 returns 0x00 or 0x01.
- R3: A write to 0x092 with data value 0x02 set (MSB-first bit 6) sets `endian_err_o`. The flag stays set through later writes and clears only on reset. Bit 0x02 is never stored in the soft-reset register.
- R4: A write to 0x81C keeps data AND 0xF0. A read of 0x81C returns that masked byte.
- R5: A write to 0x850 keeps data value 0x01 as the map flag and drives `map_noncontig_o` with it. A read of 0x850 returns 0x00 or 0x01.
- R6: A read of 0x80C returns `equip_strap`, and a read of 0x852 returns `board_id_strap`, as sampled at the read edge.
- R7: A read of 0x818 returns 0x00.
- R8: A read of any other address, including the write-only ports 0x808, 0x810, 0x812 and 0x814, returns 0xFF. A write to any address other than 0x092, 0x81C and 0x850 changes no register and no output.
- R9: `io_rdata` takes its new value at the clock edge where `io_rd` is sampled high. It holds that value while `io_rd` is low.
- R10: When a read and a write hit the same register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| equip_strap | input | 8 | Equipment strap pins |
| board_id_strap | input | 8 | Board identity strap pins |
| soft_reset_o | output | 1 | Soft-reset request |
| map_noncontig_o | output | 1 | Non-contiguous I/O map select |
| endian_err_o | output | 1 | Sticky unsupported-endian error |

## Verification
A read and a write can fall in the same cycle. When both target one register, the read must see the contents from before the write. The bench provokes this by raising both strobes together on the control port with a new pattern. It expects the prior byte on that read and the new byte on the following read.

In one soft-reset write, the stored flag and the error flag are both set from the same byte. An exhaustive sweep of all 256 data values judges the flag, the output and the error in that same cycle.

// File: rtl/sysio_regs.sv
module sysio_regs #(
  parameter int          ADDR_W      = 12,
  parameter logic [7:0]  CTL_KEEP    = 8'hF0,
  parameter logic [7:0]  UNMAPPED_RD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [7:0]        equip_strap,
  input  logic [7:0]        board_id_strap,
  output logic              soft_reset_o,
  output logic              map_noncontig_o,
  output logic              endian_err_o
);
  localparam logic [ADDR_W-1:0] P_SRST  = ADDR_W'(12'h092);
  localparam logic [ADDR_W-1:0] P_EQUIP = ADDR_W'(12'h80C);
  localparam logic [ADDR_W-1:0] P_KEY   = ADDR_W'(12'h818);
  localparam logic [ADDR_W-1:0] P_CTL   = ADDR_W'(12'h81C);
  localparam logic [ADDR_W-1:0] P_MAP   = ADDR_W'(12'h850);
  localparam logic [ADDR_W-1:0] P_BID   = ADDR_W'(12'h852);

  // MSB-first bit numbering: bit n lives at position 7-n
  localparam int SRST_POS = 7 - 7;
  localparam int LE_POS   = 7 - 6;
  localparam int MAP_POS  = 7 - 7;

  logic       srst_q, map_q, err_q;
  logic [7:0] ctl_q, rd_q, rd_mux;

  wire wr_srst = io_wr && (io_addr == P_SRST);
  wire wr_ctl  = io_wr && (io_addr == P_CTL);
  wire wr_map  = io_wr && (io_addr == P_MAP);

  always_comb begin
    if      (io_addr == P_SRST)  rd_mux = {7'b0, srst_q} << SRST_POS;
    else if (io_addr == P_EQUIP) rd_mux = equip_strap;
    else if (io_addr == P_KEY)   rd_mux = 8'h00;
    else if (io_addr == P_CTL)   rd_mux = ctl_q;
    else if (io_addr == P_MAP)   rd_mux = {7'b0, map_q} << MAP_POS;
    else if (io_addr == P_BID)   rd_mux = board_id_strap;
    else                         rd_mux = UNMAPPED_RD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      map_q  <= 1'b1;
      err_q  <= 1'b0;
      ctl_q  <= 8'h00;
      rd_q   <= 8'h00;
    end else begin
      if (wr_srst) begin
        srst_q <= io_wdata[SRST_POS];
        if (io_wdata[LE_POS]) err_q <= 1'b1;
      end
      if (wr_ctl) ctl_q <= io_wdata & CTL_KEEP;
      if (wr_map) map_q <= io_wdata[MAP_POS];
      if (io_rd)  rd_q  <= rd_mux;
    end
  end

  assign io_rdata        = rd_q;
  assign soft_reset_o    = srst_q;
  assign map_noncontig_o = map_q;
  assign endian_err_o    = err_q;
endmodule

// File: rtl/sysio_regs_chk.sv
module sysio_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              soft_reset_o,
  input logic              map_noncontig_o,
  input logic              endian_err_o
);
  wire hit_srst = io_wr && (io_addr == ADDR_W'(12'h092));
  wire hit_map  = io_wr && (io_addr == ADDR_W'(12'h850));

  // R2
  srst_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_srst |=> soft_reset_o == $past(io_wdata[0]));
  // R2
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_srst |=> $stable(soft_reset_o));
  // R3
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_srst && io_wdata[1]) |=> endian_err_o);
  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    endian_err_o |=> endian_err_o);
  // R5
  map_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_map |=> map_noncontig_o == $past(io_wdata[0]));
  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_map |=> $stable(map_noncontig_o));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
endmodule

bind sysio_regs sysio_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .soft_reset_o(soft_reset_o),
  .map_noncontig_o(map_noncontig_o), .endian_err_o(endian_err_o)
);

// File: tb/sysio_regs_test.sv
`timescale 1ns/1ps
module sysio_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [7:0]  equip_strap = 8'hA5, board_id_strap = 8'h3C;
  logic        soft_reset_o, map_noncontig_o, endian_err_o;

  int n_chk = 0, n_bad = 0;
  logic       m_sr = 1'b0, m_map = 1'b1, m_err = 1'b0;
  logic [7:0] m_ctl = 8'h00;

  always #2.5 clk = ~clk;

  sysio_regs uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .equip_strap(equip_strap),
    .board_id_strap(board_id_strap), .soft_reset_o(soft_reset_o),
    .map_noncontig_o(map_noncontig_o), .endian_err_o(endian_err_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h092: return {7'b0, m_sr};
      12'h80C: return equip_strap;
      12'h818: return 8'h00;
      12'h81C: return m_ctl;
      12'h850: return {7'b0, m_map};
      12'h852: return board_id_strap;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_sr = 1'b0; m_map = 1'b1; m_err = 1'b0; m_ctl = 8'h00;
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic outs(input string tag);
    chk({tag, " soft_reset_o"}, {7'b0, soft_reset_o}, {7'b0, m_sr});
    chk({tag, " map_noncontig_o"}, {7'b0, map_noncontig_o}, {7'b0, m_map});
    chk({tag, " endian_err_o"}, {7'b0, endian_err_o}, {7'b0, m_err});
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    do_reset();
    @(negedge clk);
    chk("R1 rdata after reset", io_rdata, 8'h00);
    outs("R1");
    do_rd(12'h81C, d); chk("R1 ctl reset", d, 8'h00);
    do_rd(12'h850, d); chk("R1 map reset", d, 8'h01);
    do_rd(12'h092, d); chk("R1 srst reset", d, 8'h00);

    for (int a = 0; a < 4096; a++) begin
      if (a[3:0] == 4'h0) begin
        equip_strap = 8'(a * 7); board_id_strap = 8'(a ^ 8'h96);
      end
      do_rd(12'(a), d);
      chk($sformatf("R6 R7 R8 read addr %h", a), d, exp_rd(12'(a)));
    end

    for (int v = 0; v < 256; v++) begin
      do_wr(12'h092, 8'(v));
      m_sr = v[0];
      if (v[1]) m_err = 1'b1;
      outs($sformatf("R2 R3 wr092 %h", v));
      do_rd(12'h092, d); chk($sformatf("R2 rd092 %h", v), d, {7'b0, m_sr});
    end

    for (int v = 0; v < 256; v++) begin
      do_wr(12'h81C, 8'(v));
      m_ctl = 8'(v) & 8'hF0;
      do_rd(12'h81C, d); chk($sformatf("R4 ctl %h", v), d, m_ctl);
    end

    for (int v = 0; v < 256; v++) begin
      do_wr(12'h850, 8'(v));
      m_map = v[0];
      outs($sformatf("R5 wr850 %h", v));
      do_rd(12'h850, d); chk($sformatf("R5 rd850 %h", v), d, {7'b0, m_map});
    end

    do_reset();
    @(negedge clk);
    outs("R3 reset clears err");
    do_wr(12'h092, 8'h01); m_sr = 1'b1;
    do_wr(12'h81C, 8'h5A); m_ctl = 8'h50;
    do_wr(12'h850, 8'h00); m_map = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      if (a != 12'h092 && a != 12'h81C && a != 12'h850) begin
        @(negedge clk); io_addr = 12'(a); io_wdata = 8'(~a); io_wr = 1'b1;
      end
    end
    @(negedge clk); io_wr = 1'b0;
    outs("R8 stray writes");
    do_rd(12'h092, d); chk("R8 srst kept", d, 8'h01);
    do_rd(12'h81C, d); chk("R8 ctl kept", d, 8'h50);
    do_rd(12'h850, d); chk("R8 map kept", d, 8'h00);

    @(negedge clk); io_addr = 12'h81C; io_wdata = 8'hC3; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
    chk("R10 same-cycle read sees old", io_rdata, 8'h50);
    m_ctl = 8'hC0;
    do_rd(12'h81C, d); chk("R10 next read sees new", d, 8'hC0);

    equip_strap = 8'h11;
    @(negedge clk); io_addr = 12'h80C; io_rd = 1'b1;
    #1 chk("R9 rdata before edge", io_rdata, 8'hC0);
    @(negedge clk); io_rd = 1'b0;
    chk("R9 rdata after edge", io_rdata, 8'h11);
    equip_strap = 8'h77; io_addr = 12'h852;
    repeat (3) @(negedge clk);
    chk("R9 rdata held", io_rdata, 8'h11);

    finish_run();
  end
endmodule